// File: doc/BRIEF.md
# Direct-Mapped Page Translation Buffer

This block holds recently used page translations so that address translation can skip the page table walk. A lookup presents a 30-bit virtual page number (VPN) and, within the same cycle, learns whether a translation is cached and, if so, receives the stored page table entry (PTE). That PTE is the one a full multi-level walk would deliver, not program data.

The storage works like a direct-mapped cache whose key is the VPN. No bits are spent on an in-block offset. The low VPN bits pick one of the entries, and the remaining high bits are kept as a tag. When a walk finishes after a miss, its PTE and VPN are presented on the refill port. The entry selected by that VPN is overwritten at the next clock edge, so the next lookup of that VPN hits. A flush input empties the whole buffer in one cycle.

Each entry is a two-state machine. The states are `SLOT_EMPTY` and `SLOT_LIVE`. The transitions are:
- fill (`SLOT_EMPTY` to `SLOT_LIVE`, or `SLOT_LIVE` to `SLOT_LIVE` with a new tag) when a refill targets the entry without a flush;
- drop (any state to `SLOT_EMPTY`) on flush;
- hold otherwise.

Top module: `tlb_dm`

## Requirements
- R1: During and right after reset, every lookup reports a miss.
- R2: After a refill of VPN v with PTE p, a lookup of v in any later cycle reports hit with p on `lk_pte`, until that entry is overwritten or flushed.
- R3: The entry index is VPN[3:0] and the tag is VPN[29:4]. A lookup whose index matches a cached entry but whose tag differs reports a miss.
- R4: A refill overwrites whatever occupies its index. After it, the previous VPN at that index misses and the new one hits.
- R5: Translations at different indices are retained together. All 16 indices can hold a live entry at once.
- R6: A flush makes every lookup miss from the next cycle on, until new refills arrive.
- R7: When flush and refill are asserted in the same cycle, the flush wins and the refilled VPN misses afterwards.
- R8: A lookup of the same VPN that is being refilled in that cycle reports a miss for that cycle. The refill still installs the entry.
- R9: Whenever `lk_hit` is 0, `lk_pte` is all zeros.
- R10: A refill in progress does not disturb a same-cycle lookup of a different VPN. That lookup reflects the buffer contents from before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 30 | VPN to translate |
| lk_hit | output | 1 | Translation present (combinational) |
| lk_pte | output | 32 | Cached PTE on hit, zero on miss |
| fill_en | input | 1 | Install a walk result this cycle |
| fill_vpn | input | 30 | VPN of the walk result |
| fill_pte | input | 32 | Final PTE from the walk |
| flush | input | 1 | Invalidate all entries |

## Verification
A lookup result is combinational, so it belongs to the same cycle as the VPN that produced it. A refill or flush passes through one register and changes lookup results from the first cycle after the edge that captured it. The bench drives inputs on the falling edge and compares `lk_hit` and `lk_pte` a quarter period later against a behavioural model. That model is a map from full VPN to PTE, and it is updated only after the rising edge. The same-cycle rules for a refill colliding with a lookup (R8, R10) are therefore judged against the model contents from before the update.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_LIVE  = 1'b1
    } slot_state_t;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
#(
    parameter int TAG_W = 26,
    parameter int PTE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic             flush,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PTE_W-1:0] wr_pte,
    output logic             live,
    output logic [TAG_W-1:0] tag_q,
    output logic [PTE_W-1:0] pte_q
);

    slot_state_t state_q, state_d;
    logic        do_fill;

    assign do_fill = wr_sel && !flush;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: fill, drop, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (do_fill) state_d = SLOT_LIVE;
            end
            SLOT_LIVE: begin
                if (flush) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // payload is rewritten only on a fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            pte_q <= '0;
        end else if (do_fill) begin
            tag_q <= wr_tag;
            pte_q <= wr_pte;
        end
    end

    // outputs
    always_comb begin
        live = (state_q == SLOT_LIVE);
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int VPN_W   = 30,
    parameter int ENTRIES = 16,
    parameter int PTE_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = VPN_W - IDX_W
) (
    input  logic [ENTRIES-1:0]            slot_live,
    input  logic [ENTRIES-1:0][TAG_W-1:0] slot_tag,
    input  logic [ENTRIES-1:0][PTE_W-1:0] slot_pte,
    input  logic [VPN_W-1:0]              lk_vpn,
    input  logic                          fill_en,
    input  logic [VPN_W-1:0]              fill_vpn,
    output logic                          hit,
    output logic [PTE_W-1:0]              pte
);

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             sel_live;
    logic [TAG_W-1:0] sel_tag;
    logic [PTE_W-1:0] sel_pte;
    logic             collide;

    assign idx = lk_vpn[IDX_W-1:0];
    assign tag = lk_vpn[VPN_W-1:IDX_W];

    always_comb begin
        sel_live = slot_live[idx];
        sel_tag  = slot_tag[idx];
        sel_pte  = slot_pte[idx];
    end

    // a refill of the very VPN being looked up defers the hit by a cycle
    assign collide = fill_en && (fill_vpn == lk_vpn);

    always_comb begin
        hit = sel_live && (sel_tag == tag) && !collide;
        pte = hit ? sel_pte : '0;
    end

endmodule

// File: rtl/tlb_dm.sv
module tlb_dm #(
    parameter int VPN_W   = 30,
    parameter int ENTRIES = 16,
    parameter int PTE_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PTE_W-1:0] lk_pte,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             flush
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = VPN_W - IDX_W;

    logic [IDX_W-1:0]            fill_idx;
    logic [TAG_W-1:0]            fill_tag;
    logic [ENTRIES-1:0]          wr_sel;
    logic [ENTRIES-1:0]          slot_live;
    logic [ENTRIES-1:0][TAG_W-1:0] slot_tag;
    logic [ENTRIES-1:0][PTE_W-1:0] slot_pte;

    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign wr_sel[g] = fill_en && (fill_idx == IDX_W'(g));

        tlb_slot #(
            .TAG_W (TAG_W),
            .PTE_W (PTE_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_sel[g]),
            .flush  (flush),
            .wr_tag (fill_tag),
            .wr_pte (fill_pte),
            .live   (slot_live[g]),
            .tag_q  (slot_tag[g]),
            .pte_q  (slot_pte[g])
        );
    end

    tlb_match #(
        .VPN_W   (VPN_W),
        .ENTRIES (ENTRIES),
        .PTE_W   (PTE_W)
    ) u_match (
        .slot_live (slot_live),
        .slot_tag  (slot_tag),
        .slot_pte  (slot_pte),
        .lk_vpn    (lk_vpn),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .hit       (lk_hit),
        .pte       (lk_pte)
    );

endmodule

// File: rtl/tlb_dm_chk.sv
module tlb_dm_chk #(
    parameter int VPN_W   = 30,
    parameter int ENTRIES = 16,
    parameter int PTE_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic [PTE_W-1:0] lk_pte,
    input logic             fill_en,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PTE_W-1:0] fill_pte,
    input logic             flush
);

    localparam int IDX_W = $clog2(ENTRIES);

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pte == '0));

    // R8
    same_vpn_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_vpn == lk_vpn) |-> !lk_hit);

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R2
    refill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=>
            ((lk_vpn == $past(fill_vpn) && !(fill_en && fill_vpn == lk_vpn))
                ? (lk_hit && lk_pte == $past(fill_pte)) : 1'b1));

    // R3
    tag_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=>
            ((lk_vpn[IDX_W-1:0] == $past(fill_vpn[IDX_W-1:0]) &&
              lk_vpn[VPN_W-1:IDX_W] != $past(fill_vpn[VPN_W-1:IDX_W]))
                ? !lk_hit : 1'b1));

endmodule

bind tlb_dm tlb_dm_chk #(
    .VPN_W   (VPN_W),
    .ENTRIES (ENTRIES),
    .PTE_W   (PTE_W)
) u_chk (.*);

// File: tb/sim_tlb_dm.sv
module sim_tlb_dm;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] lk_vpn = '0;
    logic        lk_hit;
    logic [31:0] lk_pte;
    logic        fill_en = 1'b0;
    logic [29:0] fill_vpn = '0;
    logic [31:0] fill_pte = '0;
    logic        flush = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // behavioural model: full VPN -> PTE
    logic [31:0] model [logic [29:0]];

    always #(CLK_P/2) clk = ~clk;

    tlb_dm u0 (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_pte(lk_pte), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_pte(fill_pte), .flush(flush)
    );

    task automatic compare(input string req, input logic eh, input logic [31:0] ep);
        checks++;
        if (lk_hit !== eh || lk_pte !== ep) begin
            errors++;
            $display("FAIL %s vpn=%h hit=%b pte=%h expected hit=%b pte=%h",
                     req, lk_vpn, lk_hit, lk_pte, eh, ep);
        end
    endtask

    task automatic step(input string req, input logic [29:0] lv, input logic fe,
                        input logic [29:0] fv, input logic [31:0] fp, input logic fl);
        logic        eh;
        logic [31:0] ep;
        logic [29:0] drop [$];
        lk_vpn = lv; fill_en = fe; fill_vpn = fv; fill_pte = fp; flush = fl;
        #(CLK_P/4);
        eh = model.exists(lv) && !(fe && fv == lv);
        ep = eh ? model[lv] : 32'h0;
        compare(req, eh, ep);
        @(posedge clk);
        if (fl) begin
            model.delete();
        end else if (fe) begin
            foreach (model[k]) if (k[3:0] == fv[3:0]) drop.push_back(k);
            foreach (drop[j]) model.delete(drop[j]);
            model[fv] = fp;
        end
        @(negedge clk);
    endtask

    task automatic look(input string req, input logic [29:0] lv);
        step(req, lv, 1'b0, 30'h0, 32'h0, 1'b0);
    endtask

    initial begin
        #(CLK_P*150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        lk_vpn = 30'h1234567;
        #(CLK_P*2 + CLK_P/4);
        compare("R1", 1'b0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        look("R1", 30'h1234567);
        look("R1", 30'h0);

        // refill with same-VPN lookup, then hit
        step("R8", 30'h13, 1'b1, 30'h13, 32'hAAAA0001, 1'b0);
        look("R2", 30'h13);
        look("R9", 30'h14);
        // overwrite index 3 while looking up the old VPN
        step("R10", 30'h13, 1'b1, 30'h23, 32'hBBBB0002, 1'b0);
        look("R4", 30'h13);
        look("R4", 30'h23);
        look("R3", 30'h3FFFFFF3);
        // second index
        step("R2", 30'h23, 1'b1, 30'h20000005, 32'hCCCC0003, 1'b0);
        look("R5", 30'h20000005);
        look("R5", 30'h23);
        look("R3", 30'h00000015);
        // flush with concurrent refill
        step("R7", 30'h23, 1'b1, 30'h11, 32'hDDDD0004, 1'b1);
        look("R7", 30'h11);
        look("R6", 30'h23);
        look("R6", 30'h20000005);
        // fill every index, then read all back
        for (int i = 0; i < 16; i++)
            step("R5", 30'h0, 1'b1, 30'((i * 7 + 9) << 4) | 30'(i),
                 32'hE0000000 | 32'(i * 3), 1'b0);
        for (int i = 0; i < 16; i++)
            look("R5", 30'((i * 7 + 9) << 4) | 30'(i));
        for (int i = 0; i < 16; i++)
            look("R3", 30'((i * 7 + 10) << 4) | 30'(i));
        step("R6", 30'h99, 1'b0, 30'h0, 32'h0, 1'b1);
        for (int i = 0; i < 16; i++)
            look("R6", 30'((i * 7 + 9) << 4) | 30'(i));
        step("R2", 30'h3FFFFFFF, 1'b1, 30'h3FFFFFFF, 32'hFFFF1234, 1'b0);
        look("R2", 30'h3FFFFFFF);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule